// File: doc/BRIEF.md
# Trap Protection Controller

This block is the fault-shutdown stage that sits between a bank of PWM-style channel generators and the device pins. One of sixteen external trap pins is picked by a selector and brought into the clock domain through a two-flop synchronizer. A configurable edge on that pin puts the block into a trap state. While the trap state holds, every channel with its trap enable set is driven to its programmed passive level. Channels without trap enable are passed through untouched. Only an explicit software clear ends the trap state.

Software can also force a trap with a strobe. A separate strobe sets only the trap flag, for testing the interrupt path, and does not force any output. The trap flag and the trap state are separate bits, and each has its own clear strobe. The synchronized level of the selected pin is readable at all times. A one-cycle interrupt pulse reports every event that sets the flag, when the trap interrupt is enabled.

Top module: `trap_guard`

## Requirements
- R1: `pinSel` picks trap source `trapPins[pinSel]` (value n selects pin n). Edges on the other pins have no effect on the flags or the outputs.
- R2: With `edgeFall`=0 a low-to-high transition of the selected pin is a trap event; with `edgeFall`=1 a high-to-low transition is. The flags change on the third rising clock edge after the pin changes.
- R3: A trap event sets both `trapFlag` and `trapState`.
- R4: While `trapState` is 1, each channel with `chTrapEn[i]`=1 drives `chOut[i]` = `chPassiveHigh[i]`. A polarity bit of 0 means active high, so the output is low; a bit of 1 means active low, so the output is high.
- R5: A channel with `chTrapEn[i]`=0 always drives `chOut[i]` = `chRaw[i]`, in the trap state too. Every channel does so while `trapState` is 0.
- R6: A `swTrapSet` pulse sets both flags and forces the trap. A `swFlagSet` pulse sets only `trapFlag` and leaves `trapState` and the outputs unchanged.
- R7: A `swTrapClr` pulse clears `trapState` and returns the channels to normal output without touching `trapFlag`. A `swFlagClr` pulse clears only `trapFlag`.
- R8: `trapLevel` shows the level of the selected pin two clock edges after it changes.
- R9: `irq` is a one-cycle pulse in the cycle after any event that sets `trapFlag` (pin trap, `swTrapSet` or `swFlagSet`), if `trapIrqEn` is 1. It stays 0 when `trapIrqEn` is 0.
- R10: When a set and a clear of the same bit arrive in the same cycle, the set wins. This covers a trap event or `swTrapSet` together with `swTrapClr`, and a flag set together with `swFlagClr`.
- R11: After reset both flags and `irq` are 0. No edge is detected until the synchronizer is filled, so a pin already at the trigger level during reset causes no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapPins | input | 16 | Asynchronous trap pins |
| pinSel | input | 4 | Trap source selector |
| edgeFall | input | 1 | 0 = rising edge traps, 1 = falling edge traps |
| chTrapEn | input | 9 | Per-channel trap enable |
| chPassiveHigh | input | 9 | Per-channel polarity: 1 = passive level high |
| chRaw | input | 9 | Channel waveforms from the generators |
| trapIrqEn | input | 1 | Trap interrupt enable |
| swTrapSet | input | 1 | Write-one strobe: force a trap |
| swTrapClr | input | 1 | Write-one strobe: leave the trap state |
| swFlagSet | input | 1 | Write-one strobe: set the trap flag only |
| swFlagClr | input | 1 | Write-one strobe: clear the trap flag only |
| chOut | output | 9 | Final channel pins |
| trapFlag | output | 1 | Trap event flag |
| trapState | output | 1 | Trap state flag |
| trapLevel | output | 1 | Synchronized level of the selected pin |
| irq | output | 1 | Trap interrupt pulse |

## Verification
The bench builds the block with its default parameters: sixteen pins, nine channels and two synchronizer stages. With sixteen pins the bench can show that an edge on an unselected pin is ignored. With nine channels, enable and polarity patterns can mix forced-low, forced-high and pass-through channels in one trap. The two-stage synchronizer sets a fixed three-edge latency, so the bench can place a clear strobe in exactly the cycle in which a pin trap is detected.

// File: rtl/trap_guard_pkg.sv
`timescale 1ns/1ps
package trap_guard_pkg;
  // Resolved one-cycle commands from the control to the datapath.
  typedef struct packed {
    logic enterTrap;
    logic exitTrap;
    logic raiseFlag;
    logic dropFlag;
    logic irqFire;
  } tg_strobe_t;
endpackage

// File: rtl/trap_guard_ctrl.sv
`timescale 1ns/1ps
module trap_guard_ctrl
  import trap_guard_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] trapPins,
  input  logic [SEL_W-1:0]    pinSel,
  input  logic                edgeFall,
  input  logic                trapIrqEn,
  input  logic                swTrapSet,
  input  logic                swTrapClr,
  input  logic                swFlagSet,
  input  logic                swFlagClr,
  output logic                trapLevel,
  output tg_strobe_t          strb
);
  localparam int ARM_CYCLES = SYNC_STAGES + 1;
  localparam int ARM_W      = $clog2(ARM_CYCLES + 1);

  logic                   pinMux;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [ARM_W-1:0]       armCnt;
  logic                   armed;
  logic                   levelNow;
  logic                   hwEdge;

  // Select first, then synchronize only one bit.
  assign pinMux = trapPins[pinSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinMux};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  // Edge detection stays off until the pipeline holds real pin samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (!armed) begin
      armCnt <= armCnt + 1'b1;
    end
  end

  assign armed    = (armCnt == ARM_W'(ARM_CYCLES));
  assign levelNow = syncQ[SYNC_STAGES-1];
  assign hwEdge   = armed & (levelNow ^ prevQ) & (levelNow ^ edgeFall);

  // Priority resolution: set always beats clear.
  always_comb begin
    strb.enterTrap = hwEdge | swTrapSet;
    strb.exitTrap  = swTrapClr & ~strb.enterTrap;
    strb.raiseFlag = strb.enterTrap | swFlagSet;
    strb.dropFlag  = swFlagClr & ~strb.raiseFlag;
    strb.irqFire   = strb.raiseFlag & trapIrqEn;
  end

  assign trapLevel = levelNow;

  AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    hwEdge |-> (trapLevel != $past(trapLevel))) else $error("edge without change"); // R2

  AST_EDGE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    hwEdge |-> (trapLevel == ~edgeFall)) else $error("edge of wrong direction"); // R2
endmodule

// File: rtl/trap_guard_dp.sv
`timescale 1ns/1ps
module trap_guard_dp
  import trap_guard_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  tg_strobe_t        strb,
  input  logic [NUM_CH-1:0] chTrapEn,
  input  logic [NUM_CH-1:0] chPassiveHigh,
  input  logic [NUM_CH-1:0] chRaw,
  output logic [NUM_CH-1:0] chOut,
  output logic              trapFlag,
  output logic              trapState,
  output logic              irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapState <= 1'b0;
      trapFlag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (strb.enterTrap)     trapState <= 1'b1;
      else if (strb.exitTrap) trapState <= 1'b0;
      if (strb.raiseFlag)     trapFlag  <= 1'b1;
      else if (strb.dropFlag) trapFlag  <= 1'b0;
      irq <= strb.irqFire;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chOut[i] = (trapState & chTrapEn[i]) ? chPassiveHigh[i] : chRaw[i];
  end

  AST_ENTER_SETS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterTrap |=> (trapState && trapFlag)) else $error("trap not taken"); // R3

  AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.raiseFlag && !strb.enterTrap && !trapState) |=> !trapState) else $error("flag set trapped"); // R6

  AST_CLEAR_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.exitTrap |=> !trapState) else $error("trap not left"); // R7

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> trapFlag) else $error("irq without flag"); // R9

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq || $past(strb.irqFire)) else $error("irq stuck"); // R9
endmodule

// File: rtl/trap_guard.sv
`timescale 1ns/1ps
module trap_guard
  import trap_guard_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int NUM_CH      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] trapPins,
  input  logic [SEL_W-1:0]    pinSel,
  input  logic                edgeFall,
  input  logic [NUM_CH-1:0]   chTrapEn,
  input  logic [NUM_CH-1:0]   chPassiveHigh,
  input  logic [NUM_CH-1:0]   chRaw,
  input  logic                trapIrqEn,
  input  logic                swTrapSet,
  input  logic                swTrapClr,
  input  logic                swFlagSet,
  input  logic                swFlagClr,
  output logic [NUM_CH-1:0]   chOut,
  output logic                trapFlag,
  output logic                trapState,
  output logic                trapLevel,
  output logic                irq
);
  tg_strobe_t strb;

  trap_guard_ctrl #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trapPins (trapPins),
    .pinSel   (pinSel),
    .edgeFall (edgeFall),
    .trapIrqEn(trapIrqEn),
    .swTrapSet(swTrapSet),
    .swTrapClr(swTrapClr),
    .swFlagSet(swFlagSet),
    .swFlagClr(swFlagClr),
    .trapLevel(trapLevel),
    .strb     (strb)
  );

  trap_guard_dp #(
    .NUM_CH(NUM_CH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .chTrapEn     (chTrapEn),
    .chPassiveHigh(chPassiveHigh),
    .chRaw        (chRaw),
    .chOut        (chOut),
    .trapFlag     (trapFlag),
    .trapState    (trapState),
    .irq          (irq)
  );
endmodule

// File: tb/tb_trap_guard.sv
`timescale 1ns/1ps
module tb_trap_guard;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] trapPins;
  logic [3:0]  pinSel;
  logic        edgeFall;
  logic [8:0]  chTrapEn, chPassiveHigh, chRaw;
  logic        trapIrqEn, swTrapSet, swTrapClr, swFlagSet, swFlagClr;
  logic [8:0]  chOut;
  logic        trapFlag, trapState, trapLevel, irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk; // 125 MHz

  trap_guard dut (
    .clk(clk), .rstN(rstN), .trapPins(trapPins), .pinSel(pinSel),
    .edgeFall(edgeFall), .chTrapEn(chTrapEn), .chPassiveHigh(chPassiveHigh),
    .chRaw(chRaw), .trapIrqEn(trapIrqEn), .swTrapSet(swTrapSet),
    .swTrapClr(swTrapClr), .swFlagSet(swFlagSet), .swFlagClr(swFlagClr),
    .chOut(chOut), .trapFlag(trapFlag), .trapState(trapState),
    .trapLevel(trapLevel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expOut(input logic trapped);
    return trapped ? ((chRaw & ~chTrapEn) | (chPassiveHigh & chTrapEn)) : chRaw;
  endfunction

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pulse(input logic ts, input logic tc, input logic fs, input logic fc);
    @(negedge clk);
    swTrapSet = ts; swTrapClr = tc; swFlagSet = fs; swFlagClr = fc;
    @(negedge clk);
    swTrapSet = 0; swTrapClr = 0; swFlagSet = 0; swFlagClr = 0;
    #1;
  endtask

  task automatic t_reset();
    rstN = 0; trapPins = 16'hFFFF; pinSel = 4'd0; edgeFall = 0;
    chTrapEn = 9'b1_0101_0011; chPassiveHigh = 9'b0_0100_0001; chRaw = 9'b1_1010_1110;
    trapIrqEn = 1; swTrapSet = 0; swTrapClr = 0; swFlagSet = 0; swFlagClr = 0;
    waitNeg(3);
    rstN = 1;
    waitNeg(8);
    chk("R11 state after reset", trapState, 0);
    chk("R11 flag after reset", trapFlag, 0);
    chk("R11 irq after reset", irq, 0);
    chk("R5 outputs follow raw untrapped", chOut, chRaw);
  endtask

  task automatic t_rising();
    trapPins = 16'h0000; pinSel = 4'd5; edgeFall = 0;
    waitNeg(5);
    @(negedge clk); trapPins[5] = 1'b1;
    waitNeg(1);
    chk("R8 level not yet", trapLevel, 0);
    waitNeg(1);
    chk("R8 level after two edges", trapLevel, 1);
    chk("R2 no trap before third edge", trapState, 0);
    waitNeg(1);
    chk("R3 state set", trapState, 1);
    chk("R3 flag set", trapFlag, 1);
    chk("R9 irq pulse", irq, 1);
    chk("R4 passive levels forced", chOut, expOut(1));
    waitNeg(1);
    chk("R9 irq one cycle", irq, 0);
    chRaw = ~chRaw; #1;
    chk("R5 unenabled channels pass in trap", chOut, expOut(1));
  endtask

  task automatic t_clear();
    pulse(0, 0, 0, 1);
    chk("R7 flag clear drops flag", trapFlag, 0);
    chk("R7 flag clear keeps state", trapState, 1);
    pulse(0, 1, 0, 0);
    chk("R7 trap clear leaves state", trapState, 0);
    chk("R7 outputs back to raw", chOut, chRaw);
  endtask

  task automatic t_unselected();
    @(negedge clk); trapPins[3] = 1'b1;
    waitNeg(5);
    chk("R1 unselected pin ignored state", trapState, 0);
    chk("R1 unselected pin ignored flag", trapFlag, 0);
  endtask

  task automatic t_falling();
    pinSel = 4'd3; edgeFall = 1;
    waitNeg(4);
    chk("R2 no trap in falling mode yet", trapState, 0);
    @(negedge clk); trapPins[3] = 1'b0;
    waitNeg(2);
    chk("R2 falling not before third edge", trapState, 0);
    waitNeg(1);
    chk("R2 falling edge traps", trapState, 1);
    chk("R8 level low", trapLevel, 0);
    pulse(0, 1, 0, 1);
    chk("R7 both cleared", {trapState, trapFlag}, 0);
  endtask

  task automatic t_sw();
    trapIrqEn = 0;
    @(negedge clk); swFlagSet = 1;
    @(negedge clk); swFlagSet = 0; #1;
    chk("R6 flag set only flag", trapFlag, 1);
    chk("R6 flag set no trap", trapState, 0);
    chk("R9 no irq when disabled", irq, 0);
    chk("R6 outputs untouched", chOut, chRaw);
    pulse(0, 0, 0, 1);
    trapIrqEn = 1;
    @(negedge clk); swTrapSet = 1;
    @(negedge clk); swTrapSet = 0; #1;
    chk("R6 sw trap state", trapState, 1);
    chk("R6 sw trap flag", trapFlag, 1);
    chk("R9 irq on sw trap", irq, 1);
    chk("R4 sw trap forces", chOut, expOut(1));
    pulse(0, 1, 0, 1);
  endtask

  task automatic t_race();
    edgeFall = 0;
    waitNeg(2);
    @(negedge clk); trapPins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); swTrapClr = 1;
    @(negedge clk); swTrapClr = 0; #1;
    chk("R10 edge beats trap clear", trapState, 1);
    pulse(0, 1, 0, 1);
    pulse(0, 0, 1, 1);
    chk("R10 flag set beats flag clear", trapFlag, 1);
    chk("R10 no trap from flag race", trapState, 0);
    pulse(1, 1, 0, 0);
    chk("R10 sw set beats trap clear", trapState, 1);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rising();
    t_clear();
    t_unselected();
    t_falling();
    t_sw();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule